// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave-mode serial audio input port with three data lines. An external bit clock and an external word-select clock arrive as plain inputs. The block samples them with its own system clock, finds bit-clock rising edges and word-select transitions, and then rebuilds a left and a right sample for each data line. All three lines share one framing, which is picked by a 3-bit format code. The code covers LSB-justified framing at 16, 20 or 24 bits, MSB-justified framing at 24 bits (20-bit data is accepted left-aligned), and I2S framing at 24 or 16 bits. Every sample leaves the block as a signed 24-bit word. A one-cycle strobe marks each completed left/right pair.

The format code is loaded while the power-down input is high and is frozen from the moment power-down is released. A controller state machine has four states:
- **OFF**: held in power-down.
- **HUNT**: waiting for a trustworthy word-select edge.
- **RUN**: decoding.
- **BAD**: a reserved format code was latched.

The transitions are:
- OFF→HUNT on release with a legal code.
- OFF→BAD on release with a reserved code.
- HUNT→RUN on the first qualified edge.
- Any state→OFF whenever power-down is raised.

In RUN, a half-frame with fewer bit clocks than the format needs sets a sticky setup-error flag, and that pair is dropped.

Top module: `sar_rx`

## Requirements
- R1: Format code 0 decodes 16-bit LSB-justified data. The captured word is sign-extended to 24 bits. The left word is the half where word-select is high.
- R2: Codes 1 and 4 decode 20-bit and 24-bit LSB-justified data. The word is the last N bits sampled before the word-select edge that closes the half, sign-extended to 24 bits. Bits before those N are ignored.
- R3: Code 2 decodes MSB-justified data. The first 24 bits sampled from the word-select edge onward form the word, MSB first.
- R4: Code 3 decodes I2S data. The left half is where word-select is low, and the MSB comes one bit clock after the word-select edge. When a half has fewer than 24 bit clocks (16 at a ratio of 32 per frame), its bits are left-aligned with zeros below.
- R5: The three data lines are decoded at the same time under one format. Output bits [24*i+23:24*i] carry line i.
- R6: The format code is sampled only while power-down is high. Changes after release have no effect.
- R7: `valid_o` is a one-cycle pulse per completed left/right pair. The sample outputs change only at that pulse.
- R8: The minimum bit clocks per half-frame are 16, 20, 24, 16 and 24 for codes 0 to 4. A shorter half sets `bad_o` and its pair produces no pulse; later pairs decode normally.
- R9: Codes 5 to 7 are reserved. With one of them latched, `bad_o` rises right after release, the outputs stay zero and `valid_o` never pulses.
- R10: Reset or power-down clears the outputs, `valid_o` and `bad_o`. Once set, `bad_o` stays set until one of these happens.
- R11: The partial half in progress at release is discarded. The first pulse reports the first pair that starts after a qualified word-select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down; high holds the block and loads the format code |
| fmt | input | 3 | Format code |
| bclk | input | 1 | External serial bit clock |
| ws | input | 1 | External word-select clock |
| sdata | input | 3 | Serial data lines, one bit per line |
| left_o | output | 72 | Left samples, 24 bits per line |
| right_o | output | 72 | Right samples, 24 bits per line |
| valid_o | output | 1 | One-cycle pulse per decoded pair |
| bad_o | output | 1 | Sticky setup-error flag |

## Verification
The bench goes after the edges of each framing.
- **LSB filler bits:** random bits come before the word in the LSB modes. A design that counts from the wrong end of the half would fold them into the sample.
- **I2S one-bit delay:** the MSB comes one bit clock late, and at 24 bit clocks per half the last bit of a word falls on the next edge. A design without the delay loses that bit or shifts every word.
- **32 bit clocks per frame:** the bench runs this ratio in I2S, where it is legal, and in 20-bit mode, where it is not. This catches a minimum table that is wrong in either direction.
- **Other cases:** a single short frame in mid-stream, a reserved code, and a code change after release. Each exposes a design that keeps stale pairs, pulses in error, or re-reads the code.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        K_LSB,
        K_MSB,
        K_I2S,
        K_RSV
    } kind_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_RUN,
        ST_BAD
    } st_t;

endpackage

// File: rtl/sar_fmt_decode.sv
module sar_fmt_decode
    import sar_pkg::*;
(
    input  logic [2:0] fmt,
    output kind_t      kind,
    output logic [4:0] wl,
    output logic [5:0] minh
);

    always_comb begin
        unique case (fmt)
            3'd0: begin kind = K_LSB; wl = 5'd16; minh = 6'd16; end
            3'd1: begin kind = K_LSB; wl = 5'd20; minh = 6'd20; end
            3'd2: begin kind = K_MSB; wl = 5'd24; minh = 6'd24; end
            3'd3: begin kind = K_I2S; wl = 5'd24; minh = 6'd16; end
            3'd4: begin kind = K_LSB; wl = 5'd24; minh = 6'd24; end
            default: begin kind = K_RSV; wl = 5'd24; minh = 6'd32; end
        endcase
    end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pdn,
    input  logic          bclk,
    input  logic          ws,
    input  kind_t         kind,
    input  logic [5:0]    minh,
    output logic          rise_o,
    output logic          edge_o,
    output logic [CW-1:0] cnt_o,
    output logic          cap_left_o,
    output logic          cap_pair_o,
    output logic          valid_o,
    output logic          bad_o,
    output st_t           st_o
);

    st_t           st_q, st_d;
    logic          bclk_q, ws_last, eff_last, left_ok;
    logic [CW-1:0] cnt_q;
    logic          eff_now, short_half;

    assign rise_o     = bclk & ~bclk_q;
    // I2S data lags word-select by one bit: use the delayed, inverted select
    assign eff_now    = (kind == K_I2S) ? ~ws_last : ws;
    assign edge_o     = rise_o && (eff_now != eff_last);
    assign short_half = cnt_q < CW'(minh);
    assign cnt_o      = cnt_q;
    assign st_o       = st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d       = st_q;
        cap_left_o = 1'b0;
        cap_pair_o = 1'b0;
        unique case (st_q)
            ST_OFF:  if (!pdn) st_d = (kind == K_RSV) ? ST_BAD : ST_HUNT;
            ST_HUNT: if (edge_o && cnt_q >= CW'(2)) st_d = ST_RUN;
            ST_RUN: begin
                if (edge_o && !short_half) begin
                    if (eff_last)     cap_left_o = 1'b1;
                    else if (left_ok) cap_pair_o = 1'b1;
                end
            end
            ST_BAD:  st_d = ST_BAD;
        endcase
        if (pdn) begin
            st_d       = ST_OFF;
            cap_left_o = 1'b0;
            cap_pair_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            ws_last  <= 1'b0;
            eff_last <= 1'b0;
            cnt_q    <= '0;
            left_ok  <= 1'b0;
            valid_o  <= 1'b0;
            bad_o    <= 1'b0;
        end else if (pdn) begin
            bclk_q   <= bclk;
            ws_last  <= 1'b0;
            eff_last <= 1'b0;
            cnt_q    <= '0;
            left_ok  <= 1'b0;
            valid_o  <= 1'b0;
            bad_o    <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            valid_o <= cap_pair_o;
            if (st_q == ST_BAD) bad_o <= 1'b1;
            if (rise_o) begin
                ws_last  <= ws;
                eff_last <= eff_now;
                if (edge_o)          cnt_q <= CW'(1);
                else if (cnt_q != '1) cnt_q <= cnt_q + CW'(1);
            end
            if (st_q == ST_RUN && edge_o) begin
                if (short_half) begin
                    bad_o   <= 1'b1;
                    left_ok <= 1'b0;
                end else begin
                    left_ok <= eff_last;
                end
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BAD) |-> !valid_o);

    // R10
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_o && !pdn) |=> bad_o);

    // R10
    pdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!valid_o && !bad_o));

endmodule

// File: rtl/sar_lane.sv
module sar_lane
    import sar_pkg::*;
#(
    parameter int SW = 24,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rise,
    input  logic          edge_i,
    input  logic          sd,
    input  kind_t         kind,
    input  logic [4:0]    wl,
    input  logic [CW-1:0] cnt,
    input  logic          cap_left,
    input  logic          cap_pair,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o
);

    logic [SW-1:0] sr, acc, held, word;
    logic [4:0]    sh;
    logic [5:0]    n;

    always_comb begin
        sh = 5'(SW) - wl;
        n  = (cnt >= CW'(SW)) ? 6'(SW) : 6'(cnt);
        if (kind == K_LSB) word = SW'($signed(sr << sh) >>> sh);
        else               word = acc << (6'(SW) - n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            acc     <= '0;
            held    <= '0;
            left_o  <= '0;
            right_o <= '0;
        end else if (clr) begin
            sr      <= '0;
            acc     <= '0;
            held    <= '0;
            left_o  <= '0;
            right_o <= '0;
        end else begin
            if (rise) begin
                sr <= {sr[SW-2:0], sd};
                if (edge_i)                acc <= {{(SW-1){1'b0}}, sd};
                else if (cnt < CW'(SW))    acc <= {acc[SW-2:0], sd};
            end
            if (cap_left) held <= word;
            if (cap_pair) begin
                left_o  <= held;
                right_o <= word;
            end
        end
    end

    // R7
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_pair && !clr) |=> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
#(
    parameter int LANES = 3,
    parameter int SW    = 24,
    parameter int CW    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pdn,
    input  logic [2:0]            fmt,
    input  logic                  bclk,
    input  logic                  ws,
    input  logic [LANES-1:0]      sdata,
    output logic [LANES*SW-1:0]   left_o,
    output logic [LANES*SW-1:0]   right_o,
    output logic                  valid_o,
    output logic                  bad_o
);

    logic [2:0]    fmt_q;
    kind_t         kind;
    logic [4:0]    wl;
    logic [5:0]    minh;
    logic          rise, edge_s, cap_left, cap_pair;
    logic [CW-1:0] cnt;
    st_t           st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fmt_q <= 3'd0;
        else if (pdn) fmt_q <= fmt;
    end

    sar_fmt_decode u_dec (
        .fmt  (fmt_q),
        .kind (kind),
        .wl   (wl),
        .minh (minh)
    );

    sar_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pdn        (pdn),
        .bclk       (bclk),
        .ws         (ws),
        .kind       (kind),
        .minh       (minh),
        .rise_o     (rise),
        .edge_o     (edge_s),
        .cnt_o      (cnt),
        .cap_left_o (cap_left),
        .cap_pair_o (cap_pair),
        .valid_o    (valid_o),
        .bad_o      (bad_o),
        .st_o       (st)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sar_lane #(.SW(SW), .CW(CW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (pdn),
            .rise     (rise),
            .edge_i   (edge_s),
            .sd       (sdata[i]),
            .kind     (kind),
            .wl       (wl),
            .cnt      (cnt),
            .cap_left (cap_left),
            .cap_pair (cap_pair),
            .left_o   (left_o[i*SW +: SW]),
            .right_o  (right_o[i*SW +: SW])
        );
    end

    // R6
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && $past(!pdn)) |-> $stable(fmt_q));

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BAD) |-> (left_o == '0 && right_o == '0));

endmodule

// File: tb/sim_sar_rx.sv
module sim_sar_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pdn = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic        bclk = 1'b0;
    logic        ws = 1'b0;
    logic [2:0]  sdata = 3'd0;
    logic [71:0] left_o, right_o;
    logic        valid_o, bad_o;

    int    errs = 0;
    int    checks = 0;
    int    nvalid = 0;
    string cur_tag = "R1";
    bit    prev_bit [3];
    logic [71:0] expL[$];
    logic [71:0] expR[$];
    logic [71:0] popL, popR;

    always #5 clk = ~clk;

    sar_rx u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn     (pdn),
        .fmt     (fmt),
        .bclk    (bclk),
        .ws      (ws),
        .sdata   (sdata),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o),
        .bad_o   (bad_o)
    );

    task automatic chk(bit ok, string tag, logic [143:0] act, logic [143:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            nvalid++;
            if (expL.size() == 0) begin
                chk(1'b0, {cur_tag, " R7 unexpected pulse"}, {left_o, right_o}, '0);
            end else begin
                popL = expL.pop_front();
                popR = expR.pop_front();
                chk({left_o, right_o} == {popL, popR}, {cur_tag, " pair"},
                    {left_o, right_o}, {popL, popR});
            end
        end
    end

    function automatic int min_half(int mode);
        case (mode)
            0: return 16;
            1: return 20;
            3: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] exp_word(logic [23:0] w, int wl, bit lsb);
        logic [23:0] t;
        t = w << (24 - wl);
        if (lsb) return 24'($signed(t) >>> (24 - wl));
        return t;
    endfunction

    task automatic tick(bit wsv, logic [2:0] d);
        @(negedge clk);
        ws = wsv; sdata = d; bclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    // plays one half-frame; lws is the logical channel (1 = left)
    task automatic half(int mode, bit lws, int h, logic [23:0] w [3], int wl, bit lsb);
        for (int p = 0; p < h; p++) begin
            logic [2:0] d;
            bit b;
            for (int i = 0; i < 3; i++) begin
                b = 1'($urandom_range(0, 1));
                if (lsb) begin
                    if (p >= h - wl) b = w[i][h - 1 - p];
                end else if (p < wl) begin
                    b = w[i][wl - 1 - p];
                end
                if (mode == 3) begin
                    d[i] = prev_bit[i];
                    prev_bit[i] = b;
                end else begin
                    d[i] = b;
                end
            end
            tick((mode == 3) ? ~lws : lws, d);
        end
    endtask

    task automatic frame(int mode, int h, bit push);
        logic [23:0] wa [3];
        logic [23:0] wb [3];
        logic [71:0] el, er;
        int wl;
        bit lsb;
        lsb = (mode == 0 || mode == 1 || mode == 4);
        if (mode == 0)      wl = 16;
        else if (mode == 1) wl = 20;
        else if (lsb)       wl = 24;
        else                wl = (h < 24) ? h : 24;
        for (int i = 0; i < 3; i++) begin
            wa[i] = 24'($urandom) & ((24'(1) << wl) - 24'(1));
            wb[i] = 24'($urandom) & ((24'(1) << wl) - 24'(1));
            if (wl == 24) begin
                wa[i] = 24'($urandom);
                wb[i] = 24'($urandom);
            end
            el[24*i +: 24] = exp_word(wa[i], wl, lsb);
            er[24*i +: 24] = exp_word(wb[i], wl, lsb);
        end
        half(mode, 1'b1, h, wa, wl, lsb);
        half(mode, 1'b0, h, wb, wl, lsb);
        if (push && mode < 5) begin
            expL.push_back(el);
            expR.push_back(er);
        end
    endtask

    task automatic start(int mode);
        @(negedge clk);
        pdn = 1'b1; fmt = 3'(mode); bclk = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && bad_o == 1'b0 && left_o == '0 && right_o == '0,
            "R10 power-down clears", {valid_o, bad_o, left_o}, '0);
        pdn = 1'b0;
        for (int i = 0; i < 3; i++) prev_bit[i] = 1'b0;
    endtask

    task automatic lead_in(int mode, int h);
        logic [23:0] z [3];
        for (int i = 0; i < 3; i++) z[i] = '0;
        half(mode, 1'b0, h, z, 0, 1'b0);
    endtask

    task automatic trail(int mode);
        logic [23:0] z [3];
        for (int i = 0; i < 3; i++) z[i] = '0;
        half(mode, 1'b1, 16, z, 0, 1'b0);
        repeat (12) @(negedge clk);
    endtask

    task automatic run_seg(int mode, int nfr, int hfix, string tag);
        int v0, h;
        cur_tag = tag;
        start(mode);
        v0 = nvalid;
        lead_in(mode, 19);
        for (int f = 0; f < nfr; f++) begin
            h = (hfix > 0) ? hfix : $urandom_range(min_half(mode), 32);
            frame(mode, h, 1'b1);
        end
        trail(mode);
        // R11: exactly one pulse per full pair, lead-in half discarded
        chk(nvalid - v0 == nfr, {tag, " R11 pulse count"}, 144'(nvalid - v0), 144'(nfr));
        chk(expL.size() == 0, {tag, " R7 pending pairs"}, 144'(expL.size()), '0);
        chk(bad_o == 1'b0, {tag, " R8 legal ratio keeps flag low"}, 144'(bad_o), '0);
    endtask

    initial begin
        int v0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0 && bad_o == 1'b0 && left_o == '0 && right_o == '0,
            "R10 reset state", {valid_o, bad_o, left_o}, '0);

        run_seg(0, 6, 0, "R1");
        run_seg(1, 6, 0, "R2");
        run_seg(4, 6, 0, "R5");
        run_seg(2, 6, 0, "R3");
        run_seg(3, 6, 0, "R4");
        run_seg(3, 4, 16, "R4");
        run_seg(3, 4, 24, "R4");
        run_seg(0, 4, 16, "R1");

        // R6: code change after release has no effect
        cur_tag = "R6";
        start(0);
        @(negedge clk);
        fmt = 3'd2;
        v0 = nvalid;
        lead_in(0, 20);
        for (int f = 0; f < 4; f++) frame(0, 32, 1'b1);
        trail(0);
        chk(nvalid - v0 == 4 && expL.size() == 0, "R6 latched code kept",
            144'(nvalid - v0), 144'(4));

        // R8: 32 bit clocks per frame is illegal in 20-bit mode
        cur_tag = "R8";
        start(1);
        v0 = nvalid;
        lead_in(1, 16);
        for (int f = 0; f < 3; f++) frame(1, 16, 1'b0);
        trail(1);
        chk(nvalid == v0, "R8 short ratio gives no pulse", 144'(nvalid - v0), '0);
        chk(bad_o == 1'b1, "R8 short ratio flag", 144'(bad_o), 144'(1));

        // R8: one short frame mid-stream is dropped, others kept
        start(0);
        v0 = nvalid;
        lead_in(0, 20);
        frame(0, 16, 1'b1);
        frame(0, 12, 1'b0);
        frame(0, 16, 1'b1);
        frame(0, 24, 1'b1);
        trail(0);
        chk(nvalid - v0 == 3 && expL.size() == 0, "R8 dropped pair only",
            144'(nvalid - v0), 144'(3));
        chk(bad_o == 1'b1, "R8 mid-stream flag", 144'(bad_o), 144'(1));
        repeat (20) @(negedge clk);
        chk(bad_o == 1'b1, "R10 flag sticky", 144'(bad_o), 144'(1));

        // R9: reserved code
        cur_tag = "R9";
        start(5);
        repeat (3) @(negedge clk);
        chk(bad_o == 1'b1, "R9 reserved flag", 144'(bad_o), 144'(1));
        v0 = nvalid;
        lead_in(5, 20);
        for (int f = 0; f < 3; f++) frame(5, 24, 1'b0);
        trail(5);
        chk(nvalid == v0, "R9 reserved no pulse", 144'(nvalid - v0), '0);
        chk(left_o == '0 && right_o == '0, "R9 reserved zero output",
            {left_o, right_o}, '0);

        @(negedge clk);
        pdn = 1'b1;
        repeat (2) @(negedge clk);
        chk(bad_o == 1'b0 && valid_o == 1'b0, "R10 power-down clears flag",
            144'(bad_o), '0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule